// File: doc/BRIEF.md
# Scaled FP8 Dot-Product Accumulator

This block forms a dot product of two vectors of 8-bit floating-point numbers and returns one dequantized single-precision result. Every accepted beat delivers one 16-bit lane for operand A and one for operand B. Each lane packs two FP8 elements, so two exact products are formed per beat. Both products are added into a single-precision accumulator, and every addition rounds to nearest even. A run of beats is framed by a start flag on its first beat and a last flag on its final beat. A format select chooses between the 4-exponent/3-mantissa encoding and the 5-exponent/2-mantissa encoding.

The two operand scales are supplied as reciprocal dequantization factors in single precision. They are sampled together with the last beat and multiplied into one combined factor. The accumulated sum is then multiplied by that factor, so the rescale uses a multiplier and needs no divider. The result appears with a one-cycle valid pulse. Any infinity or NaN code seen during a run forces the result to a quiet NaN.

Top module: `f8dot_acc`

## Requirements
- R1: While reset is asserted, and after it until the first result, `res_valid` is low and `res_data` is zero.
- R2: With `fmt_sel`=0 an element decodes with sign in bit 7, exponent in bits 6:3 (bias 7) and mantissa in bits 2:0. Exponent field 0 is subnormal, with value mant/8·2^-6. A code whose bits 6:0 are all ones is NaN and makes the run's result 0x7FC00000.
- R3: With `fmt_sel`=1 an element decodes with sign in bit 7, exponent in bits 6:2 (bias 15) and mantissa in bits 1:0. Exponent field 0 is subnormal, with value mant/4·2^-14. Exponent field 11111 (infinity or NaN) makes the run's result 0x7FC00000.
- R4: On each accepted beat, element 0 sits in lane bits 7:0 and element 1 in bits 15:8. The exact products a0·b0 and a1·b1 are both added into the accumulator, and successive beats keep accumulating.
- R5: Each single-precision addition rounds to nearest, ties to even. Within a beat the element-0 product is added first and the element-1 product second.
- R6: `start` clears the accumulator and the NaN state. When it comes with `in_valid`, that beat's products are added to zero. When it comes alone, it only clears.
- R7: For a beat with `in_valid` and `in_last`, `res_valid` pulses for one cycle, two rising edges after the edge that accepts the beat. `res_data` is then the sum multiplied by the rounded product `scale_a`·`scale_b`, both roundings to nearest even, using the scales present on that beat.
- R8: While `in_valid` is low, the lane inputs and `in_last` are ignored. The accumulator keeps its value and no result is produced.
- R9: In the final multiplies, a zero operand or a result below the normal range gives a signed zero, and a result above the range gives a signed infinity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the accumulator; marks the first beat |
| in_valid | input | 1 | Lane inputs carry a beat |
| in_last | input | 1 | Final beat of a run; triggers the rescale |
| fmt_sel | input | 1 | 0: 4-exp/3-mant elements, 1: 5-exp/2-mant elements |
| a_lane | input | LANE_W | Two packed FP8 elements of operand A |
| b_lane | input | LANE_W | Two packed FP8 elements of operand B |
| scale_a | input | 32 | FP32 reciprocal scale of operand A |
| scale_b | input | 32 | FP32 reciprocal scale of operand B |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 32 | FP32 dequantized dot product |

## Verification
The hardest situations to reach are a rounding tie inside the accumulator, and a case where the order of the two in-beat additions changes the result. Both need a running sum near 2^24, where a single product of 1 is exactly half a unit in the last place. The stimulus reaches that point in one beat with 5-exponent elements, because 4096·4096 equals 2^24. A small second product then lands on the tie. A later beat adds +1 in element 0 and -2^24 in element 1: added in the required order the result is zero, and in the reverse order it would be one.

// File: rtl/f8dot_pkg.sv
package f8dot_pkg;
  typedef enum logic {FMT_E4M3 = 1'b0, FMT_E5M2 = 1'b1} f8_fmt_e;
  localparam int F8_W = 8;
  localparam int F32_W = 32;
  localparam logic [F32_W-1:0] F32_QNAN = 32'h7FC0_0000;
endpackage

// File: rtl/f8_mul_exact.sv
module f8_mul_exact
  import f8dot_pkg::*;
(
  input  f8_fmt_e          fmt,
  input  logic [F8_W-1:0]  x,
  input  logic [F8_W-1:0]  y,
  output logic [F32_W-1:0] prod,
  output logic             special
);
  // significand as an integer; value = sig * 2^exp
  function automatic logic [3:0] el_sig(input f8_fmt_e f, input logic [7:0] c);
    if (f == FMT_E4M3) return {(c[6:3] != 4'd0), c[2:0]};
    else               return {(c[6:2] != 5'd0), c[1:0], 1'b0};
  endfunction

  function automatic int el_exp(input f8_fmt_e f, input logic [7:0] c);
    if (f == FMT_E4M3) return (c[6:3] == 4'd0) ? -9  : int'(c[6:3]) - 10;
    else               return (c[6:2] == 5'd0) ? -17 : int'(c[6:2]) - 18;
  endfunction

  function automatic logic el_special(input f8_fmt_e f, input logic [7:0] c);
    if (f == FMT_E4M3) return (c[6:0] == 7'h7F);
    else               return (c[6:2] == 5'h1F);
  endfunction

  always_comb begin : p_prod
    logic [7:0] p;
    int         e;
    int         lead;
    p    = el_sig(fmt, x) * el_sig(fmt, y);
    e    = el_exp(fmt, x) + el_exp(fmt, y);
    lead = 0;
    for (int i = 0; i < 8; i++) if (p[i]) lead = i;
    if (p == 8'd0) prod = '0;
    else prod = {x[7] ^ y[7], 8'(e + lead + 127), 23'({16'd0, p} << (23 - lead))};
    special = el_special(fmt, x) | el_special(fmt, y);
  end
endmodule

// File: rtl/f32_add_rne.sv
module f32_add_rne
  import f8dot_pkg::*;
(
  input  logic [F32_W-1:0] a,
  input  logic [F32_W-1:0] b,
  output logic [F32_W-1:0] s
);
  always_comb begin : p_add
    logic [31:0] big, sml;
    logic [23:0] mb, ms;
    logic [49:0] wide;
    logic [26:0] xb, xs, nrm;
    logic [27:0] sum;
    logic [24:0] rnd;
    logic        rup;
    int          eb, es, d, lz, ex;
    if (a[30:0] >= b[30:0]) begin big = a; sml = b; end
    else                    begin big = b; sml = a; end
    eb = int'(big[30:23]);
    es = int'(sml[30:23]);
    mb = (eb == 0) ? 24'd0 : {1'b1, big[22:0]};
    ms = (es == 0) ? 24'd0 : {1'b1, sml[22:0]};
    d  = eb - es;
    if (d > 50) d = 50;
    wide = {ms, 26'd0} >> d;
    xs   = {wide[49:24], |wide[23:0]};
    xb   = {mb, 3'd0};
    if (big[31] == sml[31]) sum = {1'b0, xb} + {1'b0, xs};
    else                    sum = {1'b0, xb} - {1'b0, xs};
    ex = eb;
    lz = 0;
    if (sum[27]) begin
      nrm = {sum[27:2], sum[1] | sum[0]};
      ex  = ex + 1;
    end else begin
      for (int i = 0; i < 27; i++) if (sum[i]) lz = 26 - i;
      nrm = sum[26:0] << lz;
      ex  = ex - lz;
    end
    rup = nrm[2] & (nrm[1] | nrm[0] | nrm[3]);
    rnd = {1'b0, nrm[26:3]} + 25'(rup);
    if (rnd[24]) begin
      rnd = rnd >> 1;
      ex  = ex + 1;
    end
    if (sum == 28'd0 || ex <= 0) s = '0;
    else if (ex >= 255)          s = {big[31], 8'hFF, 23'd0};
    else                         s = {big[31], 8'(ex), rnd[22:0]};
  end
endmodule

// File: rtl/f32_mul_rne.sv
module f32_mul_rne
  import f8dot_pkg::*;
(
  input  logic [F32_W-1:0] a,
  input  logic [F32_W-1:0] b,
  output logic [F32_W-1:0] p
);
  always_comb begin : p_mul
    logic [47:0] m;
    logic [23:0] keep;
    logic        g, st, sg;
    logic [24:0] rnd;
    int          ex;
    sg = a[31] ^ b[31];
    m  = 48'({1'b1, a[22:0]}) * 48'({1'b1, b[22:0]});
    ex = int'(a[30:23]) + int'(b[30:23]) - 127;
    if (m[47]) begin
      keep = m[47:24]; g = m[23]; st = |m[22:0]; ex = ex + 1;
    end else begin
      keep = m[46:23]; g = m[22]; st = |m[21:0];
    end
    rnd = {1'b0, keep} + 25'(g & (st | keep[0]));
    if (rnd[24]) begin
      rnd = rnd >> 1;
      ex  = ex + 1;
    end
    if (a[30:23] == 8'hFF || b[30:23] == 8'hFF)           p = F32_QNAN;
    else if (a[30:23] == 8'd0 || b[30:23] == 8'd0 || ex <= 0) p = {sg, 31'd0};
    else if (ex >= 255)                                    p = {sg, 8'hFF, 23'd0};
    else                                                   p = {sg, 8'(ex), rnd[22:0]};
  end
endmodule

// File: rtl/f8dot_acc.sv
module f8dot_acc
  import f8dot_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic              fmt_sel,
  input  logic [LANE_W-1:0] a_lane,
  input  logic [LANE_W-1:0] b_lane,
  input  logic [31:0]       scale_a,
  input  logic [31:0]       scale_b,
  output logic              res_valid,
  output logic [31:0]       res_data
);
  localparam int NUM_EL = LANE_W / F8_W;

  f8_fmt_e            fmt;
  logic [F32_W-1:0]   prod  [NUM_EL];
  logic [F32_W-1:0]   chain [NUM_EL+1];
  logic [NUM_EL-1:0]  spec;
  logic [F32_W-1:0]   acc_q, acc_d, sc_q, sc_d, sc_mul, res_q, res_d, res_mul;
  logic               nan_q, nan_d, fin_q, fin_d, rv_q;
  logic               acc_en, sc_en;

  assign fmt      = f8_fmt_e'(fmt_sel);
  assign chain[0] = start ? '0 : acc_q;

  // element products, then a fixed-order adder chain: element 0 first
  for (genvar g = 0; g < NUM_EL; g++) begin : g_el
    f8_mul_exact i_mul (
      .fmt    (fmt),
      .x      (a_lane[g*F8_W +: F8_W]),
      .y      (b_lane[g*F8_W +: F8_W]),
      .prod   (prod[g]),
      .special(spec[g])
    );
    f32_add_rne i_add (
      .a(chain[g]),
      .b(prod[g]),
      .s(chain[g+1])
    );
  end

  f32_mul_rne i_scl (.a(scale_a), .b(scale_b), .p(sc_mul));
  f32_mul_rne i_fin (.a(acc_q),   .b(sc_q),    .p(res_mul));

  always_comb begin : p_next
    acc_d  = acc_q;
    nan_d  = nan_q;
    if (in_valid) begin
      acc_d = chain[NUM_EL];
      nan_d = (nan_q & ~start) | (|spec);
    end else if (start) begin
      acc_d = '0;
      nan_d = 1'b0;
    end
    acc_en = in_valid | start;
    fin_d  = in_valid & in_last;
    sc_en  = fin_d;
    sc_d   = sc_mul;
    res_d  = nan_q ? F32_QNAN : res_mul;
  end

  always_ff @(posedge clk or negedge rst_n) begin : p_regs
    if (!rst_n) begin
      acc_q <= '0;
      nan_q <= 1'b0;
      sc_q  <= '0;
      fin_q <= 1'b0;
      res_q <= '0;
      rv_q  <= 1'b0;
    end else begin
      if (acc_en) begin
        acc_q <= acc_d;
        nan_q <= nan_d;
      end
      if (sc_en) sc_q  <= sc_d;
      if (fin_q) res_q <= res_d;
      fin_q <= fin_d;
      rv_q  <= fin_q;
    end
  end

  assign res_valid = rv_q;
  assign res_data  = res_q;
endmodule

// File: rtl/f8dot_acc_chk.sv
module f8dot_acc_chk
  import f8dot_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              in_valid,
  input logic              in_last,
  input logic [LANE_W-1:0] a_lane,
  input logic [LANE_W-1:0] b_lane,
  input logic [F32_W-1:0]  acc_q,
  input logic              res_valid,
  input logic [F32_W-1:0]  res_data
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) reset_quiet_chk: assert (!res_valid && res_data == '0);
  end

  // R7
  last_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |-> ##2 res_valid);

  // R7
  valid_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid && in_last, 2));

  // R6
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !in_valid) |=> (acc_q == '0));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !start) |=> (acc_q == $past(acc_q)));

  // R4
  zero_beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !start && a_lane == '0 && b_lane == '0) |=> (acc_q == $past(acc_q)));
endmodule

bind f8dot_acc f8dot_acc_chk #(.LANE_W(LANE_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .in_valid (in_valid),
  .in_last  (in_last),
  .a_lane   (a_lane),
  .b_lane   (b_lane),
  .acc_q    (acc_q),
  .res_valid(res_valid),
  .res_data (res_data)
);

// File: tb/test_f8dot_acc.sv
`timescale 1ns/1ps
module test_f8dot_acc;
  logic        clk, rst_n, start, in_valid, in_last, fmt_sel;
  logic [15:0] a_lane, b_lane;
  logic [31:0] scale_a, scale_b, res_data;
  logic        res_valid;
  int          total = 0;
  int          bad = 0;

  f8dot_acc #(.LANE_W(16)) i_f8dot_acc (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_last(in_last),
    .fmt_sel(fmt_sel), .a_lane(a_lane), .b_lane(b_lane), .scale_a(scale_a),
    .scale_b(scale_b), .res_valid(res_valid), .res_data(res_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  localparam int NV = 10;
  // two beats per vector; lane = {element1, element0}
  localparam logic        VM  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic [15:0] VA0 [NV] = '{16'h3840, 16'h007E, 16'h0101, 16'h3E40, 16'h3E6C,
                                       16'h3C6C, 16'h3C7C, 16'h007F, 16'h0040, 16'h0038};
  localparam logic [15:0] VB0 [NV] = '{16'h443C, 16'h007E, 16'h3838, 16'hC03C, 16'h406C,
                                       16'h3C6C, 16'h3C3C, 16'h0038, 16'h0038, 16'h0038};
  localparam logic [15:0] VA1 [NV] = '{16'h30B8, 16'h0000, 16'h0007, 16'h0100, 16'h0000,
                                       16'hEC3C, 16'h0000, 16'h0000, 16'h0000, 16'h0000};
  localparam logic [15:0] VB1 [NV] = '{16'h4040, 16'h0000, 16'h0038, 16'h7B00, 16'h0000,
                                       16'h6C3C, 16'h0000, 16'h0000, 16'h0000, 16'h0000};
  localparam logic [31:0] VSA [NV] = '{32'h3F800000, 32'h3F000000, 32'h44000000, 32'h3F800000,
                                       32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h3F800000,
                                       32'h71800000, 32'h0D800000};
  localparam logic [31:0] VSB [NV] = '{32'h40000000, 32'h3E800000, 32'h3F800000, 32'hC1000000,
                                       32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h3F800000,
                                       32'h4D000000, 32'h0D800000};
  localparam logic [31:0] VEX [NV] = '{32'h41200000, 32'h46C40000, 32'h41100000, 32'h3F800000,
                                       32'h4B800002, 32'h00000000, 32'h7FC00000, 32'h7FC00000,
                                       32'h7F800000, 32'h00000000};

  function automatic string vec_req(input int i);
    case (i)
      0: return "R4 mixed-sign E4M3";
      1: return "R2 E4M3 maximum 448";
      2: return "R2 E4M3 subnormal";
      3: return "R3 E5M2 subnormal and negative scale";
      4: return "R5 tie to even upward";
      5: return "R5 add order element0 first";
      6: return "R3 E5M2 infinity to NaN";
      7: return "R2 E4M3 NaN code";
      8: return "R9 overflow to infinity";
      default: return "R9 underflow to zero";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic beat(input logic st, input logic v, input logic l, input logic [15:0] a,
                      input logic [15:0] b, input logic [31:0] sa, input logic [31:0] sb);
    @(negedge clk);
    start = st; in_valid = v; in_last = l; a_lane = a; b_lane = b; scale_a = sa; scale_b = sb;
  endtask

  // inputs idle: lanes and in_last carry junk that must be ignored
  task automatic idle();
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0; in_last = 1'b1;
    a_lane = 16'($urandom); b_lane = 16'($urandom);
  endtask

  // last beat accepted at edge k; result visible after edge k+1 for one cycle
  task automatic expect_res(input logic [31:0] exp, input string req);
    idle();
    @(negedge clk);
    chk(res_valid === 1'b1, {req, " valid"}, {31'd0, res_valid}, 32'd1);
    chk(res_data === exp, req, res_data, exp);
    @(negedge clk);
    chk(res_valid === 1'b0, {req, " R7 pulse width"}, {31'd0, res_valid}, 32'd0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R7 watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_last = 1'b0; fmt_sel = 1'b0;
    a_lane = '0; b_lane = '0; scale_a = '0; scale_b = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(res_valid === 1'b0 && res_data === 32'd0, "R1 reset outputs", res_data, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(res_valid === 1'b0, "R1 after reset", {31'd0, res_valid}, 32'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      fmt_sel = VM[i];
      beat(1'b1, 1'b1, 1'b0, VA0[i], VB0[i], 32'h0, 32'h0);
      beat(1'b0, 1'b1, 1'b1, VA1[i], VB1[i], VSA[i], VSB[i]);
      expect_res(VEX[i], vec_req(i));
    end

    // R8: idle cycles with junk lanes and in_last between beats
    fmt_sel = 1'b0;
    beat(1'b1, 1'b1, 1'b0, 16'h3840, 16'h443C, 32'h0, 32'h0);
    idle();
    chk(res_valid === 1'b0, "R8 no result while idle", {31'd0, res_valid}, 32'd0);
    idle();
    @(negedge clk);
    chk(res_valid === 1'b0, "R8 no result after idle last", {31'd0, res_valid}, 32'd0);
    beat(1'b0, 1'b1, 1'b1, 16'h30B8, 16'h4040, 32'h3F800000, 32'h40000000);
    expect_res(32'h41200000, "R8 idle ignored");

    // R6: start alone clears a partial sum
    beat(1'b1, 1'b1, 1'b0, 16'h0038, 16'h0038, 32'h0, 32'h0);
    beat(1'b1, 1'b0, 1'b0, 16'h0038, 16'h0038, 32'h0, 32'h0);
    beat(1'b0, 1'b1, 1'b1, 16'h0040, 16'h0038, 32'h3F800000, 32'h3F800000);
    expect_res(32'h40000000, "R6 start-only clear");

    // R4: three beats accumulate 1 + 1 + 2
    beat(1'b1, 1'b1, 1'b0, 16'h0038, 16'h0038, 32'h0, 32'h0);
    beat(1'b0, 1'b1, 1'b0, 16'h3800, 16'h3800, 32'h0, 32'h0);
    beat(1'b0, 1'b1, 1'b1, 16'h0040, 16'h0038, 32'h3F800000, 32'h3F800000);
    expect_res(32'h40800000, "R4 multi-beat accumulation");

    // R7: single beat carrying both start and last; scale 1*3
    beat(1'b1, 1'b1, 1'b1, 16'h4040, 16'h3838, 32'h3F800000, 32'h40400000);
    expect_res(32'h41400000, "R7 single-beat run");

    finish_run();
  end
endmodule